// File: doc/BRIEF.md
# Character Display Instruction Executor

This block carries out the command set of a text-mode character display controller. A host presents one byte at a time with a strobe and a flag that marks the byte as a command or as a character. The block keeps the cursor address, the entry direction and auto-shift bits, the panel, cursor and blink enables, the bus-width, line-count and font bits, and a whole-display shift offset. It writes into an external 80-cell character RAM and a 64-byte glyph pattern RAM through a single registered write port.

Every accepted byte raises busy for a fixed number of cycles. Strobes that arrive while busy is high are dropped. Clearing the screen and returning home hold busy longer. Clearing fills every valid cell with the space code, one cell per cycle, walking the address map of the current line mode. After reset the block runs the same fill by itself, loads its power-on modes and keeps busy high until a separate start-up wait ends.

Top module: `chr_disp_exec`

## Requirements
- R1: From reset, busy is high. The block writes 0x20 to addresses 0x00 through 0x4F in rising order, one per cycle, and then holds busy for INIT_WAIT more cycles. Busy stays high for 80+INIT_WAIT cycles counted from the first rising edge after reset. The power-on modes are: 8-bit bus on, one line, small font, panel/cursor/blink off, increment on, auto-shift off, cursor address 0, display target selected, offset 0.
- R2: Command 0x01 (clear) writes 0x20 to all 80 valid cells of the current line mode in rising map order. It sets the cursor address and offset to 0, selects the display target and forces increment. Busy lasts 80+BUSY_LONG cycles.
- R3: Commands 0x02 and 0x03 (home) set the cursor address and offset to 0 and select the display target. They write nothing and hold busy for BUSY_LONG cycles.
- R4: A character byte (data flag 1) is written once to the selected RAM at the cursor address. For the pattern target the written address is the low six bits of the cursor address. The write shows on the port in the cycle after the accepting edge, and the cursor address then steps.
- R5: Command 000001IS sets the direction bit I (bit 1: 1 increments, 0 decrements) and the auto-shift bit S (bit 0). Pattern accesses step the low six address bits modulo 64.
- R6: With S=1, each character write to the display target also moves the offset: +1 when incrementing and -1 when decrementing. Pattern writes never move it.
- R7: Display-target stepping in two-line mode goes 0x27→0x40 and 0x67→0x00 on increment, and 0x40→0x27 and 0x00→0x67 on decrement. In one-line mode it goes 0x4F→0x00 and 0x00→0x4F. Any other address steps by one within seven bits.
- R8: Command 0001 X Y xx: X (bit 3) = 1 moves the offset (Y=1: -1, Y=0: +1) and leaves the cursor address unchanged. X=0 steps the cursor address (Y=1 forward, Y=0 back). The offset wraps modulo 40 in two-line mode and modulo 80 in one-line mode.
- R9: Command 00001DCB sets panel (bit 2), cursor (bit 1) and blink (bit 0) enables.
- R10: Command 001 W N F xx sets the bus-width bit W (bit 4), two-line bit N (bit 3) and tall-font bit F (bit 2), and returns the offset to 0.
- R11: Command 01aaaaaa loads cursor address aaaaaa and selects the pattern target. Command 1aaaaaaa loads the seven-bit address and selects the display target.
- R12: All other accepted bytes, including the no-op 0x00, hold busy for BUSY_SHORT cycles. A strobe while busy is high changes no state and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Byte strobe, taken when busy is low |
| cmd_is_data | input | 1 | 1: character byte, 0: command byte |
| cmd_byte | input | 8 | Command or character byte |
| busy | output | 1 | Executing; strobes are ignored |
| ram_we | output | 1 | One-cycle write enable |
| ram_pat_sel | output | 1 | Write targets pattern RAM when 1 |
| ram_addr | output | 7 | Write address |
| ram_wdata | output | 8 | Write data |
| cursor_addr | output | 7 | Current cursor address |
| ac_pat_sel | output | 1 | Cursor address refers to pattern RAM |
| shift_ofs | output | 7 | Whole-display shift offset |
| disp_on | output | 1 | Panel enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| two_line | output | 1 | Two-line map selected |
| tall_font | output | 1 | Tall glyph font |
| bus_8bit | output | 1 | 8-bit host bus |
| entry_inc | output | 1 | Increment direction |
| entry_shift | output | 1 | Auto-shift on writes |

## Verification
The bench builds the block with BUSY_SHORT=3, BUSY_LONG=10 and INIT_WAIT=16. With these short hold windows, hundreds of random commands and several full 80-cell clears fit easily in the run, while the fill length stays the real 80 cells. The full address walk in both line modes is therefore checked write by write, along with every wrap point of the map and both offset wrap lengths. One strobe is injected in the middle of a clear to confirm that it is dropped.

// File: rtl/cdx_pkg.sv
package cdx_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int PAT_W     = 6;
    localparam int CELLS     = 80;
    localparam int LEN_TWO   = 40;
    localparam int LEN_ONE   = 80;

    localparam logic [ADDR_W-1:0] ROW0_END   = 7'h27;
    localparam logic [ADDR_W-1:0] ROW1_START = 7'h40;
    localparam logic [ADDR_W-1:0] ROW1_END   = 7'h67;
    localparam logic [ADDR_W-1:0] FLAT_END   = 7'h4F;
    localparam logic [BYTE_W-1:0] BLANK      = 8'h20;

    typedef enum logic [3:0] {
        OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_PANEL,
        OP_MOVE, OP_FUNC, OP_SET_PAT, OP_SET_DISP, OP_DATA
    } op_e;

    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_WAIT} state_e;

    typedef struct packed {
        logic disp;
        logic cur;
        logic blink;
        logic two;
        logic tall;
        logic bus8;
        logic inc;
        logic shift;
    } modes_t;

    localparam modes_t MODES_BOOT = '{disp: 1'b0, cur: 1'b0, blink: 1'b0, two: 1'b0,
                                      tall: 1'b0, bus8: 1'b1, inc: 1'b1, shift: 1'b0};
endpackage

// File: rtl/cdx_decode.sv
module cdx_decode import cdx_pkg::*; (
    input  logic              is_data,
    input  logic [BYTE_W-1:0] code,
    output op_e               op
);
    always_comb begin
        if (is_data)       op = OP_DATA;
        else if (code[7])  op = OP_SET_DISP;
        else if (code[6])  op = OP_SET_PAT;
        else if (code[5])  op = OP_FUNC;
        else if (code[4])  op = OP_MOVE;
        else if (code[3])  op = OP_PANEL;
        else if (code[2])  op = OP_ENTRY;
        else if (code[1])  op = OP_HOME;
        else if (code[0])  op = OP_CLEAR;
        else               op = OP_NOP;
    end
endmodule

// File: rtl/cdx_addr_step.sv
module cdx_addr_step import cdx_pkg::*; (
    input  logic [ADDR_W-1:0] addr,
    input  logic              up,
    input  logic              two_line,
    input  logic              pat,
    output logic [ADDR_W-1:0] next
);
    logic [PAT_W-1:0] pat_next;

    always_comb begin
        pat_next = up ? addr[PAT_W-1:0] + 1'b1 : addr[PAT_W-1:0] - 1'b1;
        if (pat) begin
            next = {{(ADDR_W-PAT_W){1'b0}}, pat_next};
        end else if (two_line) begin
            if (up) begin
                if (addr == ROW0_END)       next = ROW1_START;
                else if (addr == ROW1_END)  next = '0;
                else                        next = addr + 1'b1;
            end else begin
                if (addr == ROW1_START)     next = ROW0_END;
                else if (addr == '0)        next = ROW1_END;
                else                        next = addr - 1'b1;
            end
        end else begin
            if (up) next = (addr == FLAT_END) ? '0 : addr + 1'b1;
            else    next = (addr == '0) ? FLAT_END : addr - 1'b1;
        end
    end
endmodule

// File: rtl/cdx_ofs_step.sv
module cdx_ofs_step import cdx_pkg::*; (
    input  logic [ADDR_W-1:0] ofs,
    input  logic              left,
    input  logic              two_line,
    output logic [ADDR_W-1:0] next
);
    localparam logic [ADDR_W-1:0] TOP_TWO = ADDR_W'(LEN_TWO - 1);
    localparam logic [ADDR_W-1:0] TOP_ONE = ADDR_W'(LEN_ONE - 1);

    logic [ADDR_W-1:0] top;

    always_comb begin
        top = two_line ? TOP_TWO : TOP_ONE;
        if (left) next = (ofs >= top) ? '0 : ofs + 1'b1;
        else      next = (ofs == '0) ? top : ofs - 1'b1;
    end
endmodule

// File: rtl/chr_disp_exec.sv
module chr_disp_exec import cdx_pkg::*; #(
    parameter int BUSY_SHORT = 4,
    parameter int BUSY_LONG  = 40,
    parameter int INIT_WAIT  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_data,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              busy,
    output logic              ram_we,
    output logic              ram_pat_sel,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic [ADDR_W-1:0] cursor_addr,
    output logic              ac_pat_sel,
    output logic [ADDR_W-1:0] shift_ofs,
    output logic              disp_on,
    output logic              cursor_on,
    output logic              blink_on,
    output logic              two_line,
    output logic              tall_font,
    output logic              bus_8bit,
    output logic              entry_inc,
    output logic              entry_shift
);
    localparam int CNT_A   = (CELLS > BUSY_LONG) ? CELLS : BUSY_LONG;
    localparam int CNT_B   = (INIT_WAIT > BUSY_SHORT) ? INIT_WAIT : BUSY_SHORT;
    localparam int CNT_TOP = (CNT_A > CNT_B) ? CNT_A : CNT_B;
    localparam int CNT_W   = $clog2(CNT_TOP + 1);

    localparam logic [CNT_W-1:0] FILL_LAST  = CNT_W'(CELLS - 1);
    localparam logic [CNT_W-1:0] HOLD_SHORT = CNT_W'(BUSY_SHORT - 1);
    localparam logic [CNT_W-1:0] HOLD_LONG  = CNT_W'(BUSY_LONG - 1);
    localparam logic [CNT_W-1:0] HOLD_BOOT  = CNT_W'(INIT_WAIT - 1);

    typedef struct packed {
        state_e            st;
        logic              boot;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] fill_ptr;
        logic [ADDR_W-1:0] ac;
        logic              pat_sel;
        logic [ADDR_W-1:0] ofs;
        modes_t            m;
        logic              we;
        logic              wpat;
        logic [ADDR_W-1:0] waddr;
        logic [BYTE_W-1:0] wdata;
    } core_t;

    core_t r_q, r_d;

    op_e               op;
    logic              accept;
    logic              ac_up;
    logic              ofs_left;
    logic [ADDR_W-1:0] ac_next;
    logic [ADDR_W-1:0] ofs_next;
    logic [ADDR_W-1:0] fill_next;

    cdx_decode u_decode (
        .is_data (cmd_is_data),
        .code    (cmd_byte),
        .op      (op)
    );

    cdx_addr_step u_ac_step (
        .addr     (r_q.ac),
        .up       (ac_up),
        .two_line (r_q.m.two),
        .pat      (r_q.pat_sel),
        .next     (ac_next)
    );

    cdx_addr_step u_fill_step (
        .addr     (r_q.fill_ptr),
        .up       (1'b1),
        .two_line (r_q.m.two),
        .pat      (1'b0),
        .next     (fill_next)
    );

    cdx_ofs_step u_ofs_step (
        .ofs      (r_q.ofs),
        .left     (ofs_left),
        .two_line (r_q.m.two),
        .next     (ofs_next)
    );

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        accept   = cmd_valid && (r_q.st == ST_IDLE);
        ac_up    = (op == OP_MOVE) ? cmd_byte[2] : r_q.m.inc;
        ofs_left = (op == OP_MOVE) ? !cmd_byte[2] : r_q.m.inc;

        unique case (r_q.st)
            ST_FILL: begin
                r_d.we       = 1'b1;
                r_d.wpat     = 1'b0;
                r_d.waddr    = r_q.fill_ptr;
                r_d.wdata    = BLANK;
                r_d.fill_ptr = fill_next;
                r_d.cnt      = r_q.cnt + 1'b1;
                if (r_q.cnt == FILL_LAST) begin
                    r_d.st   = ST_WAIT;
                    r_d.cnt  = r_q.boot ? HOLD_BOOT : HOLD_LONG;
                    r_d.boot = 1'b0;
                end
            end
            ST_WAIT: begin
                if (r_q.cnt == '0) r_d.st  = ST_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            default: begin
                if (accept) begin
                    r_d.st  = ST_WAIT;
                    r_d.cnt = HOLD_SHORT;
                    unique case (op)
                        OP_DATA: begin
                            r_d.we    = 1'b1;
                            r_d.wpat  = r_q.pat_sel;
                            r_d.waddr = r_q.pat_sel
                                      ? {{(ADDR_W-PAT_W){1'b0}}, r_q.ac[PAT_W-1:0]}
                                      : r_q.ac;
                            r_d.wdata = cmd_byte;
                            r_d.ac    = ac_next;
                            if (!r_q.pat_sel && r_q.m.shift) r_d.ofs = ofs_next;
                        end
                        OP_SET_DISP: begin
                            r_d.ac      = cmd_byte[ADDR_W-1:0];
                            r_d.pat_sel = 1'b0;
                        end
                        OP_SET_PAT: begin
                            r_d.ac      = {{(ADDR_W-PAT_W){1'b0}}, cmd_byte[PAT_W-1:0]};
                            r_d.pat_sel = 1'b1;
                        end
                        OP_FUNC: begin
                            r_d.m.bus8 = cmd_byte[4];
                            r_d.m.two  = cmd_byte[3];
                            r_d.m.tall = cmd_byte[2];
                            r_d.ofs    = '0;
                        end
                        OP_MOVE: begin
                            if (cmd_byte[3]) r_d.ofs = ofs_next;
                            else             r_d.ac  = ac_next;
                        end
                        OP_PANEL: begin
                            r_d.m.disp  = cmd_byte[2];
                            r_d.m.cur   = cmd_byte[1];
                            r_d.m.blink = cmd_byte[0];
                        end
                        OP_ENTRY: begin
                            r_d.m.inc   = cmd_byte[1];
                            r_d.m.shift = cmd_byte[0];
                        end
                        OP_HOME: begin
                            r_d.ac      = '0;
                            r_d.ofs     = '0;
                            r_d.pat_sel = 1'b0;
                            r_d.cnt     = HOLD_LONG;
                        end
                        OP_CLEAR: begin
                            r_d.st       = ST_FILL;
                            r_d.cnt      = '0;
                            r_d.fill_ptr = '0;
                            r_d.ac       = '0;
                            r_d.ofs      = '0;
                            r_d.pat_sel  = 1'b0;
                            r_d.m.inc    = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_FILL;
            r_q.boot     <= 1'b1;
            r_q.cnt      <= '0;
            r_q.fill_ptr <= '0;
            r_q.ac       <= '0;
            r_q.pat_sel  <= 1'b0;
            r_q.ofs      <= '0;
            r_q.m        <= MODES_BOOT;
            r_q.we       <= 1'b0;
            r_q.wpat     <= 1'b0;
            r_q.waddr    <= '0;
            r_q.wdata    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign ram_we      = r_q.we;
    assign ram_pat_sel = r_q.wpat;
    assign ram_addr    = r_q.waddr;
    assign ram_wdata   = r_q.wdata;
    assign cursor_addr = r_q.ac;
    assign ac_pat_sel  = r_q.pat_sel;
    assign shift_ofs   = r_q.ofs;
    assign disp_on     = r_q.m.disp;
    assign cursor_on   = r_q.m.cur;
    assign blink_on    = r_q.m.blink;
    assign two_line    = r_q.m.two;
    assign tall_font   = r_q.m.tall;
    assign bus_8bit    = r_q.m.bus8;
    assign entry_inc   = r_q.m.inc;
    assign entry_shift = r_q.m.shift;
endmodule

// File: rtl/cdx_checker.sv
module cdx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       ram_we,
    input logic       ram_pat_sel,
    input logic [6:0] ram_addr,
    input logic [6:0] cursor_addr,
    input logic       ac_pat_sel,
    input logic [6:0] shift_ofs,
    input logic       disp_on,
    input logic       cursor_on,
    input logic       blink_on,
    input logic       two_line,
    input logic       tall_font,
    input logic       bus_8bit,
    input logic       entry_inc,
    input logic       entry_shift
);
    // R12: nothing visible moves on an edge where busy was already high
    a_r12_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cursor_addr) && $stable(ac_pat_sel) && $stable(shift_ofs)
                  && $stable(disp_on) && $stable(cursor_on) && $stable(blink_on)
                  && $stable(two_line) && $stable(tall_font) && $stable(bus_8bit)
                  && $stable(entry_inc) && $stable(entry_shift)));

    // R12: an accepted strobe starts a busy period
    a_r12_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R4: RAM writes only happen inside a busy period
    a_r4_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy);

    // R11: pattern addresses never exceed 64 entries
    a_r11_pat_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ((ram_we && ram_pat_sel) || ac_pat_sel) |->
        (!(ram_we && ram_pat_sel) || !ram_addr[6]) && (!ac_pat_sel || !cursor_addr[6]));

    // R8: offset stays within the line length of the current mode
    a_r8_ofs_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (two_line ? (shift_ofs < 7'd40) : (shift_ofs < 7'd80)));
endmodule

bind chr_disp_exec cdx_checker u_cdx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .busy        (busy),
    .ram_we      (ram_we),
    .ram_pat_sel (ram_pat_sel),
    .ram_addr    (ram_addr),
    .cursor_addr (cursor_addr),
    .ac_pat_sel  (ac_pat_sel),
    .shift_ofs   (shift_ofs),
    .disp_on     (disp_on),
    .cursor_on   (cursor_on),
    .blink_on    (blink_on),
    .two_line    (two_line),
    .tall_font   (tall_font),
    .bus_8bit    (bus_8bit),
    .entry_inc   (entry_inc),
    .entry_shift (entry_shift)
);

// File: tb/chr_disp_exec_test.sv
`timescale 1ns/1ps
module chr_disp_exec_test;
    localparam int BS = 3;
    localparam int BL = 10;
    localparam int IW = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid, cmd_is_data;
    logic [7:0] cmd_byte;
    logic       busy, ram_we, ram_pat_sel, ac_pat_sel;
    logic [6:0] ram_addr, cursor_addr, shift_ofs;
    logic [7:0] ram_wdata;
    logic       disp_on, cursor_on, blink_on, two_line, tall_font, bus_8bit, entry_inc, entry_shift;

    always #4 clk = ~clk;

    chr_disp_exec #(.BUSY_SHORT(BS), .BUSY_LONG(BL), .INIT_WAIT(IW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_data(cmd_is_data),
        .cmd_byte(cmd_byte), .busy(busy), .ram_we(ram_we), .ram_pat_sel(ram_pat_sel),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .cursor_addr(cursor_addr),
        .ac_pat_sel(ac_pat_sel), .shift_ofs(shift_ofs), .disp_on(disp_on),
        .cursor_on(cursor_on), .blink_on(blink_on), .two_line(two_line),
        .tall_font(tall_font), .bus_8bit(bus_8bit), .entry_inc(entry_inc),
        .entry_shift(entry_shift)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // reference model state
    logic [6:0] m_ac, m_ofs;
    logic       m_pat, m_d, m_c, m_b, m_two, m_tall, m_bus, m_inc, m_sh;
    logic [15:0] exp_w [0:79];
    int          exp_n, exp_busy;
    logic [15:0] got_w [0:79];
    int          got_n, got_busy;

    function automatic logic [6:0] f_step(input logic [6:0] a, input logic up,
                                          input logic two, input logic pat);
        logic [5:0] p;
        p = up ? a[5:0] + 6'd1 : a[5:0] - 6'd1;
        if (pat) return {1'b0, p};
        if (two) begin
            if (up) begin
                if (a == 7'h27) return 7'h40;
                if (a == 7'h67) return 7'h00;
                return a + 7'd1;
            end
            if (a == 7'h40) return 7'h27;
            if (a == 7'h00) return 7'h67;
            return a - 7'd1;
        end
        if (up) return (a == 7'h4F) ? 7'h00 : a + 7'd1;
        return (a == 7'h00) ? 7'h4F : a - 7'd1;
    endfunction

    function automatic logic [6:0] f_ofs(input logic [6:0] o, input logic left, input logic two);
        logic [6:0] top;
        top = two ? 7'd39 : 7'd79;
        if (left) return (o >= top) ? 7'd0 : o + 7'd1;
        return (o == 7'd0) ? top : o - 7'd1;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_boot();
        m_ac = 0; m_ofs = 0; m_pat = 0;
        m_d = 0; m_c = 0; m_b = 0; m_two = 0; m_tall = 0; m_bus = 1; m_inc = 1; m_sh = 0;
    endtask

    task automatic fill_expect();
        logic [6:0] a;
        a = 7'h00;
        for (int i = 0; i < 80; i++) begin
            exp_w[i] = {1'b0, a, 8'h20};
            a = f_step(a, 1'b1, m_two, 1'b0);
        end
        exp_n = 80;
    endtask

    task automatic model_apply(input logic d, input logic [7:0] b);
        exp_n = 0;
        exp_busy = BS;
        if (d) begin
            exp_w[0] = {m_pat, (m_pat ? {1'b0, m_ac[5:0]} : m_ac), b};
            exp_n = 1;
            if (!m_pat && m_sh) m_ofs = f_ofs(m_ofs, m_inc, m_two);
            m_ac = f_step(m_ac, m_inc, m_two, m_pat);
        end else if (b[7]) begin
            m_ac = b[6:0]; m_pat = 0;
        end else if (b[6]) begin
            m_ac = {1'b0, b[5:0]}; m_pat = 1;
        end else if (b[5]) begin
            m_bus = b[4]; m_two = b[3]; m_tall = b[2]; m_ofs = 0;
        end else if (b[4]) begin
            if (b[3]) m_ofs = f_ofs(m_ofs, !b[2], m_two);
            else      m_ac  = f_step(m_ac, b[2], m_two, m_pat);
        end else if (b[3]) begin
            m_d = b[2]; m_c = b[1]; m_b = b[0];
        end else if (b[2]) begin
            m_inc = b[1]; m_sh = b[0];
        end else if (b[1]) begin
            m_ac = 0; m_ofs = 0; m_pat = 0; exp_busy = BL;
        end else if (b[0]) begin
            fill_expect();
            m_ac = 0; m_ofs = 0; m_pat = 0; m_inc = 1; exp_busy = 80 + BL;
        end
    endtask

    task automatic collect(input bit intrude);
        got_n = 0;
        got_busy = 0;
        while (busy) begin
            if (ram_we) begin
                if (got_n < 80) got_w[got_n] = {ram_pat_sel, ram_addr, ram_wdata};
                got_n++;
            end
            if (intrude && got_busy == 5) begin
                cmd_valid = 1; cmd_is_data = 1; cmd_byte = 8'h55;
            end
            if (intrude && got_busy == 6) cmd_valid = 0;
            got_busy++;
            @(negedge clk);
        end
        if (ram_we) got_n++;
    endtask

    task automatic compare(input string tag);
        int lim;
        check(tag, "write count", got_n, exp_n);
        lim = (got_n < exp_n) ? got_n : exp_n;
        if (lim > 80) lim = 80;
        for (int i = 0; i < lim; i++) check(tag, "write {pat,addr,data}", got_w[i], exp_w[i]);
        check(tag, "busy cycles", got_busy, exp_busy);
        check(tag, "state {ac,pat,ofs,D,C,B,N,F,W,I,S}",
              {cursor_addr, ac_pat_sel, shift_ofs, disp_on, cursor_on, blink_on,
               two_line, tall_font, bus_8bit, entry_inc, entry_shift},
              {m_ac, m_pat, m_ofs, m_d, m_c, m_b, m_two, m_tall, m_bus, m_inc, m_sh});
    endtask

    task automatic run(input string tag, input logic d, input logic [7:0] b, input bit intrude = 0);
        while (busy) @(negedge clk);
        cmd_valid = 1; cmd_is_data = d; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 0;
        model_apply(d, b);
        collect(intrude);
        compare(tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        rst_n = 0; cmd_valid = 0; cmd_is_data = 0; cmd_byte = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        model_boot();
        check("R1", "busy in reset", busy, 1);
        check("R1", "write in reset", ram_we, 0);
        check("R1", "reset state",
              {cursor_addr, ac_pat_sel, shift_ofs, disp_on, cursor_on, blink_on,
               two_line, tall_font, bus_8bit, entry_inc, entry_shift},
              {m_ac, m_pat, m_ofs, m_d, m_c, m_b, m_two, m_tall, m_bus, m_inc, m_sh});
        rst_n = 1;
        // R1: self-run fill and start-up wait
        fill_expect();
        exp_busy = 80 + IW;
        collect(0);
        compare("R1");

        run("R4", 1, 8'h41);
        run("R4", 1, 8'h42);
        run("R5", 0, 8'h04);
        run("R5", 1, 8'h43);
        run("R12", 0, 8'h00);
        run("R10", 0, 8'h38);
        run("R11", 0, 8'hA7);
        run("R5", 0, 8'h06);
        run("R7", 1, 8'h61);
        run("R11", 0, 8'hE7);
        run("R7", 1, 8'h62);
        run("R5", 0, 8'h04);
        run("R7", 1, 8'h63);
        run("R11", 0, 8'hC0);
        run("R7", 1, 8'h64);
        run("R10", 0, 8'h30);
        run("R11", 0, 8'hCF);
        run("R5", 0, 8'h06);
        run("R7", 1, 8'h65);
        run("R5", 0, 8'h04);
        run("R7", 1, 8'h66);
        run("R10", 0, 8'h38);
        run("R6", 0, 8'h07);
        run("R6", 1, 8'h70);
        run("R6", 0, 8'h05);
        run("R6", 1, 8'h71);
        run("R6", 1, 8'h72);
        run("R11", 0, 8'h48);
        run("R6", 1, 8'h1F);
        run("R11", 0, 8'h80);
        run("R8", 0, 8'h18);
        run("R8", 0, 8'h1C);
        run("R8", 0, 8'h1C);
        run("R8", 0, 8'h14);
        run("R8", 0, 8'h10);
        run("R8", 0, 8'h10);
        run("R11", 0, 8'h7F);
        run("R5", 0, 8'h06);
        run("R5", 1, 8'h0E);
        run("R9", 0, 8'h0F);
        run("R9", 0, 8'h0A);
        run("R8", 0, 8'h18);
        run("R3", 0, 8'h02);
        run("R3", 0, 8'h03);
        run("R5", 0, 8'h04);
        run("R2", 0, 8'h01, 1);
        run("R2", 1, 8'h5A);

        for (int i = 0; i < 400; i++) begin
            int k;
            int r;
            k = $urandom % 20;
            r = $urandom % 80;
            if (k < 6)        run("R4", 1, 8'($urandom));
            else if (k < 8)   run("R11", 0, {1'b1, (m_two ? ((r < 40) ? 7'(r) : 7'(8'h40 + r - 40)) : 7'(r))});
            else if (k < 9)   run("R11", 0, {2'b01, 6'($urandom)});
            else if (k < 11)  run("R5", 0, {6'b000001, 2'($urandom)});
            else if (k < 12)  run("R9", 0, {5'b00001, 3'($urandom)});
            else if (k < 15)  run("R8", 0, {4'b0001, 2'($urandom), 2'($urandom)});
            else if (k < 16)  run("R10", 0, {3'b001, 3'($urandom), 2'($urandom)});
            else if (k < 17)  run("R3", 0, {7'b0000001, 1'($urandom)});
            else if (k < 18)  run("R12", 0, 8'h00);
            else if (k < 19 && (i % 5 == 0)) run("R2", 0, 8'h01);
            else              run("R7", 1, 8'($urandom));
        end

        done = 1;
        summary();
        $finish;
    end
endmodule